// File: doc/BRIEF.md
# Two-Channel Serial Sample Formatter

This block takes a parallel pair of 16-bit audio samples, one per channel, plus a 3-bit tag for each channel. It shifts them out one bit at a time on a serial data line, framed by a word-select line and a data-window line. A frame lasts 64 bit clocks. The left slot comes first and the right slot follows, each 32 bit clocks long. Within a slot the sample goes out most significant bit first and is followed directly by its three tag bits. The remaining bit times of the slot carry zero.

In master mode the block divides its system clock to make the bit clock and the word-select line itself. It also drives a data-window output that marks the 16 sample bits. In the two slave modes the bit clock and word select come from outside. These inputs are oversampled in the system clock domain. In the free slave mode the data window is ignored. In the gated slave mode an external data-window input decides on which bit clocks a sample bit is spent. A one-cycle accept strobe tells the producer when a new pair has been taken, which happens at the start of every left slot.

Top module: `afmt_serializer`

## Requirements
- R1: Master mode (mode_i = 2'b00). sclk_o has a period of 2*DIV_LO system clocks when div_sel_i is 0 and 2*DIV_HI when it is 1; the defaults are 4 and 6. Its high and low halves are equal. lr_o, fsync_o, sdata_o and accept_o change only in the clock cycle in which sclk_o rises.
- R2: A frame is 64 bit-clock rising edges. lr_o is 1 (left) for 32 of them and then 0 (right) for 32. The first frame after reset starts with the left slot.
- R3: Slot position 0 is the rising edge at which the word-select value changes. Positions 1 to 16 carry sample bits 15 down to 0, most significant bit first.
- R4: Positions 17, 18 and 19 carry tag bits 2, 1 and 0 of the slot's channel tag, in that order.
- R5: sdata_o is 0 at position 0 and at positions 20 to 31.
- R6: In master mode, fsync_o is 1 exactly at positions 1 to 16 of each slot. It is therefore raised one bit clock after each word-select edge.
- R7: accept_o pulses for one system clock at the start of each left slot. Both samples and both tags are captured at that moment. Input changes made later in the frame do not affect that frame's output.
- R8: The mode_i encodings are: 2'b01 selects free slave mode; 2'b10 and 2'b11 select gated slave mode. In the slave modes, sclk_o, lr_o and fsync_o are held at 0. sdata_o updates on the third system-clock edge after a rising level is applied to sclk_i.
- R9: In free slave mode, a slot starts on every sclk_i rising edge at which the sampled lr_i differs from its value at the previous rising edge. lr_i at 1 means the left slot. The bit positions follow R3 to R5, and fsync_i has no effect.
- R10: In gated slave mode, each sample bit takes one sclk_i rising edge at which fsync_i is 1. Rising edges with fsync_i at 0 output 0 and do not advance the sample. After the 16th sample bit, the next three rising edges output the tag bits whatever fsync_i is, and later edges output 0.
- R11: Reset is synchronous and active high. While it is held, sdata_o, fsync_o, lr_o, accept_o are 0 and sclk_o is at the SCLK_INV level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; in master mode this is the clock that is divided |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | 00 master, 01 free slave, 10/11 gated slave |
| div_sel_i | input | 1 | Master clock divide select: 0 uses DIV_LO, 1 uses DIV_HI |
| left_i | input | 16 | Left channel sample |
| right_i | input | 16 | Right channel sample |
| tag_l_i | input | 3 | Left channel tag, bit 2 sent first |
| tag_r_i | input | 3 | Right channel tag, bit 2 sent first |
| sclk_i | input | 1 | External bit clock (slave modes) |
| lr_i | input | 1 | External word select, 1 = left (slave modes) |
| fsync_i | input | 1 | External data window (gated slave mode) |
| sclk_o | output | 1 | Generated bit clock (master mode) |
| lr_o | output | 1 | Generated word select, 1 = left (master mode) |
| fsync_o | output | 1 | Generated data window (master mode) |
| sdata_o | output | 1 | Serial data |
| accept_o | output | 1 | One-cycle strobe when a sample pair is captured |

## Verification
In master mode every output is registered on the same system-clock edge that raises sclk_o. The bench therefore watches sclk_o at falling clock edges and checks data, window, word select and strobe in the half cycle after each rise, and checks that nothing moved at any other falling edge. In the slave modes the bench raises sclk_i at a falling edge and waits four falling edges. That covers the three-edge path through the synchronizer, the edge detector and the output register. It then compares sdata_o before lowering sclk_i again. lr_i and fsync_i are set up a full half period before each rise.

// File: rtl/afmt_pkg.sv
package afmt_pkg;

    localparam int SAMPLE_W  = 16;
    localparam int TAG_W     = 3;
    localparam int SLOT_LEN  = 32;
    localparam int FRAME_LEN = 2 * SLOT_LEN;
    localparam int SLOT_DONE = SAMPLE_W + TAG_W;
    localparam int CNT_W     = $clog2(SLOT_DONE + 1);
    localparam int FRAME_W   = $clog2(FRAME_LEN);

    typedef logic [1:0] mode_t;
    localparam mode_t MODE_MASTER     = 2'b00;
    localparam mode_t MODE_SLAVE_FREE = 2'b01;

    typedef struct packed {
        logic [SAMPLE_W-1:0] left;
        logic [SAMPLE_W-1:0] right;
        logic [TAG_W-1:0]    tag_l;
        logic [TAG_W-1:0]    tag_r;
    } pair_t;

    typedef struct packed {
        logic tick;   // bit-clock rising edge seen this cycle
        logic lr;     // word select at that edge, 1 = left
        logic gate;   // data window at that edge
    } beat_t;

    function automatic logic is_master(input mode_t m);
        return m == MODE_MASTER;
    endfunction

    function automatic logic uses_gate(input mode_t m);
        return m[1];
    endfunction

    // Bit n of the slot payload: sample MSB first, then tag MSB first.
    function automatic logic slot_bit(input pair_t p, input logic left,
                                      input logic [CNT_W-1:0] n);
        logic [SAMPLE_W-1:0] s;
        logic [TAG_W-1:0]    t;
        s = left ? p.left  : p.right;
        t = left ? p.tag_l : p.tag_r;
        if (n < CNT_W'(SAMPLE_W)) begin
            s = s << n;
            return s[SAMPLE_W-1];
        end
        t = t << (n - CNT_W'(SAMPLE_W));
        return t[TAG_W-1];
    endfunction

endpackage

// File: rtl/afmt_clkgen.sv
module afmt_clkgen
    import afmt_pkg::*;
#(
    parameter int DIV_LO = 2,
    parameter int DIV_HI = 3
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  en,
    input  logic  div_sel,
    output beat_t beat,
    output logic  phase
);
    localparam int DMAX = (DIV_HI > DIV_LO) ? DIV_HI : DIV_LO;
    localparam int PW   = $clog2(DMAX + 1);

    logic [PW-1:0]      pcnt;
    logic [PW-1:0]      div;
    logic [FRAME_W-1:0] fcnt;
    logic               oclk_en;

    assign div     = div_sel ? PW'(DIV_HI) : PW'(DIV_LO);
    assign oclk_en = en && (pcnt == div - PW'(1));

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            pcnt  <= '0;
            phase <= 1'b0;
            fcnt  <= '0;
        end else begin
            pcnt <= oclk_en ? '0 : pcnt + PW'(1);
            if (oclk_en) phase <= ~phase;
            if (oclk_en && !phase) fcnt <= fcnt + FRAME_W'(1);
        end
    end

    assign beat.tick = oclk_en && !phase;
    assign beat.lr   = ~fcnt[FRAME_W-1];
    assign beat.gate = 1'b1;

    // R1: prescaler never passes the selected divide
    p_prescale_bound_r1: assert property (@(posedge clk) disable iff (rst)
        en |-> (pcnt < div));

endmodule

// File: rtl/afmt_slave_if.sv
module afmt_slave_if
    import afmt_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter bit SCLK_INV    = 1'b0
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  sclk_in,
    input  logic  lr_in,
    input  logic  fsync_in,
    output beat_t beat
);
    logic [SYNC_STAGES:0]   sck_q;
    logic [SYNC_STAGES-1:0] lr_q;
    logic [SYNC_STAGES-1:0] fs_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_q <= '0;
            lr_q  <= '0;
            fs_q  <= '0;
        end else begin
            sck_q <= {sck_q[SYNC_STAGES-1:0], sclk_in ^ SCLK_INV};
            lr_q  <= {lr_q[SYNC_STAGES-2:0], lr_in};
            fs_q  <= {fs_q[SYNC_STAGES-2:0], fsync_in};
        end
    end

    assign beat.tick = sck_q[SYNC_STAGES-1] && !sck_q[SYNC_STAGES];
    assign beat.lr   = lr_q[SYNC_STAGES-1];
    assign beat.gate = fs_q[SYNC_STAGES-1];

    // R8: an edge is reported for one cycle only
    p_single_tick_r8: assert property (@(posedge clk) disable iff (rst)
        beat.tick |=> !beat.tick);

endmodule

// File: rtl/afmt_shifter.sv
module afmt_shifter
    import afmt_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  beat_t beat,
    input  logic  use_gate,
    input  pair_t pair_in,
    output logic  sdata,
    output logic  window,
    output logic  lr_q,
    output logic  accept
);
    pair_t            held;
    logic             last_lr;
    logic [CNT_W-1:0] dcnt;
    logic             start;
    logic             gate_ok;

    assign start   = beat.tick && (beat.lr != last_lr);
    assign gate_ok = use_gate ? beat.gate : 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            held    <= '0;
            last_lr <= 1'b0;
            dcnt    <= CNT_W'(SLOT_DONE);
            sdata   <= 1'b0;
            window  <= 1'b0;
            lr_q    <= 1'b0;
            accept  <= 1'b0;
        end else begin
            accept <= 1'b0;
            if (beat.tick) begin
                last_lr <= beat.lr;
                lr_q    <= beat.lr;
                sdata   <= 1'b0;
                window  <= 1'b0;
                if (start) begin
                    dcnt <= '0;
                    if (beat.lr) begin
                        held   <= pair_in;
                        accept <= 1'b1;
                    end
                end else if (dcnt < CNT_W'(SAMPLE_W)) begin
                    if (gate_ok) begin
                        sdata  <= slot_bit(held, last_lr, dcnt);
                        window <= 1'b1;
                        dcnt   <= dcnt + CNT_W'(1);
                    end
                end else if (dcnt < CNT_W'(SLOT_DONE)) begin
                    sdata <= slot_bit(held, last_lr, dcnt);
                    dcnt  <= dcnt + CNT_W'(1);
                end
            end
        end
    end

    // R7: strobe is a single cycle
    p_accept_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        accept |=> !accept);
    // R7: strobe only opens a left slot
    p_accept_left_r7: assert property (@(posedge clk) disable iff (rst)
        accept |-> lr_q);
    // R5: bit counter never runs past the tag bits
    p_count_bound_r5: assert property (@(posedge clk) disable iff (rst)
        dcnt <= CNT_W'(SLOT_DONE));
    // R10: a sample bit is only spent inside the data window
    p_gate_respected_r10: assert property (@(posedge clk) disable iff (rst)
        (dcnt == $past(dcnt) + CNT_W'(1) && $past(dcnt) < CNT_W'(SAMPLE_W))
        |-> $past(gate_ok));

endmodule

// File: rtl/afmt_serializer.sv
module afmt_serializer
    import afmt_pkg::*;
#(
    parameter int DIV_LO      = 2,
    parameter int DIV_HI      = 3,
    parameter int SYNC_STAGES = 2,
    parameter bit SCLK_INV    = 1'b0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [1:0]  mode_i,
    input  logic        div_sel_i,
    input  logic [15:0] left_i,
    input  logic [15:0] right_i,
    input  logic [2:0]  tag_l_i,
    input  logic [2:0]  tag_r_i,
    input  logic        sclk_i,
    input  logic        lr_i,
    input  logic        fsync_i,
    output logic        sclk_o,
    output logic        lr_o,
    output logic        fsync_o,
    output logic        sdata_o,
    output logic        accept_o
);
    logic  master;
    beat_t m_beat, s_beat, beat;
    logic  phase;
    logic  window, lr_q;
    pair_t pair;

    assign master = is_master(mode_i);
    assign pair   = '{left: left_i, right: right_i, tag_l: tag_l_i, tag_r: tag_r_i};

    afmt_clkgen #(.DIV_LO(DIV_LO), .DIV_HI(DIV_HI)) u_clkgen (
        .clk(clk), .rst(rst), .en(master), .div_sel(div_sel_i),
        .beat(m_beat), .phase(phase)
    );

    afmt_slave_if #(.SYNC_STAGES(SYNC_STAGES), .SCLK_INV(SCLK_INV)) u_slave (
        .clk(clk), .rst(rst), .sclk_in(sclk_i), .lr_in(lr_i),
        .fsync_in(fsync_i), .beat(s_beat)
    );

    assign beat = master ? m_beat : s_beat;

    afmt_shifter u_shift (
        .clk(clk), .rst(rst), .beat(beat), .use_gate(uses_gate(mode_i)),
        .pair_in(pair), .sdata(sdata_o), .window(window), .lr_q(lr_q),
        .accept(accept_o)
    );

    assign sclk_o  = master ? (phase ^ SCLK_INV) : 1'b0;
    assign lr_o    = master ? lr_q   : 1'b0;
    assign fsync_o = master ? window : 1'b0;

    // R1: word select only moves together with the generated bit clock
    p_lr_on_sclk_r1: assert property (@(posedge clk) disable iff (rst)
        (master && $past(master) && !$stable(lr_o)) |-> !$stable(sclk_o));

endmodule

// File: tb/afmt_serializer_tb_top.sv
module afmt_serializer_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  mode = 2'b00;
    logic        div_sel = 1'b0;
    logic [15:0] left_v = '0, right_v = '0;
    logic [2:0]  tl_v = '0, tr_v = '0;
    logic        sclk_in = 1'b0, lr_in = 1'b0, fs_in = 1'b0;
    logic        sclk_o, lr_o, fsync_o, sdata_o, accept_o;

    int n_chk = 0, n_err = 0, acc_seen = 0;
    bit done = 1'b0;

    // slave model state
    logic        m_last;
    int          m_dcnt;
    logic [15:0] m_l, m_r;
    logic [2:0]  m_tl, m_tr;

    always #4 clk = ~clk;

    afmt_serializer dut_i (
        .clk(clk), .rst(rst), .mode_i(mode), .div_sel_i(div_sel),
        .left_i(left_v), .right_i(right_v), .tag_l_i(tl_v), .tag_r_i(tr_v),
        .sclk_i(sclk_in), .lr_i(lr_in), .fsync_i(fs_in),
        .sclk_o(sclk_o), .lr_o(lr_o), .fsync_o(fsync_o),
        .sdata_o(sdata_o), .accept_o(accept_o)
    );

    always @(negedge clk) if (accept_o === 1'b1) acc_seen++;

    task automatic chk(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic exp_bit(input int pos, input logic [15:0] s,
                                     input logic [2:0] t);
        if (pos >= 1 && pos <= 16) return s[16-pos];
        if (pos >= 17 && pos <= 19) return t[19-pos];
        return 1'b0;
    endfunction

    function automatic string pos_req(input int pos);
        if (pos >= 1 && pos <= 16) return "R3 sample bit";
        if (pos >= 17 && pos <= 19) return "R4 tag bit";
        return "R5 idle bit";
    endfunction

    task automatic randomize_inputs();
        left_v  = 16'($urandom);
        right_v = 16'($urandom);
        tl_v    = 3'($urandom);
        tr_v    = 3'($urandom);
    endtask

    task automatic do_reset(input logic [1:0] m, input logic d);
        @(negedge clk);
        rst = 1'b1; mode = m; div_sel = d;
        sclk_in = 1'b0; lr_in = 1'b0; fs_in = 1'b0;
        m_last = 1'b0; m_dcnt = 19;
        repeat (3) @(negedge clk);
        chk(sdata_o == 1'b0 && fsync_o == 1'b0 && lr_o == 1'b0 &&
            accept_o == 1'b0 && sclk_o == 1'b0, "R11 reset state",
            {sdata_o, fsync_o, lr_o, accept_o, sclk_o}, 0);
        rst = 1'b0;
    endtask

    task automatic run_master(input logic d, input int frames);
        logic [15:0] cl = '0, cr = '0;
        logic [2:0]  ctl = '0, ctr = '0;
        int   k = 0, gap = 0, fc, pos, per;
        logic psclk, plr, pfs, psd;
        per = d ? 6 : 4;
        left_v = 16'h8001; right_v = 16'h7FFE; tl_v = 3'b101; tr_v = 3'b010;
        do_reset(2'b00, d);
        psclk = sclk_o; plr = lr_o; pfs = fsync_o; psd = sdata_o;
        while (k < frames * 64) begin
            @(negedge clk);
            gap++;
            if (sclk_o && !psclk) begin
                fc = k % 64; pos = fc % 32;
                if (fc == 0) begin
                    cl = left_v; cr = right_v; ctl = tl_v; ctr = tr_v;
                end
                chk(accept_o == (fc == 0), "R7 accept strobe", accept_o, fc == 0);
                chk(lr_o == (fc < 32), "R2 word select", lr_o, fc < 32);
                chk(fsync_o == (pos >= 1 && pos <= 16), "R6 data window",
                    fsync_o, pos >= 1 && pos <= 16);
                chk(sdata_o == exp_bit(pos, fc < 32 ? cl : cr, fc < 32 ? ctl : ctr),
                    pos_req(pos), sdata_o,
                    exp_bit(pos, fc < 32 ? cl : cr, fc < 32 ? ctl : ctr));
                if (k > 0) chk(gap == per, "R1 bit clock period", gap, per);
                gap = 0;
                k++;
                // R7: inputs change after capture and must not disturb the frame
                if (fc == 0) randomize_inputs();
            end else begin
                chk(lr_o == plr && fsync_o == pfs && sdata_o == psd && !accept_o,
                    "R1 outputs move only on bit clock rise",
                    {lr_o, fsync_o, sdata_o, accept_o}, {plr, pfs, psd, 1'b0});
            end
            psclk = sclk_o; plr = lr_o; pfs = fsync_o; psd = sdata_o;
        end
    endtask

    function automatic logic gate_pat(input int pat, input int pos);
        if (pat == 0) return (pos >= 2 && pos <= 9) || (pos >= 13 && pos <= 20);
        return pos >= 1;
    endfunction

    task automatic slave_frame(input bit gated, input int pat,
                               input logic [15:0] l, input logic [15:0] r,
                               input logic [2:0] tl, input logic [2:0] tr);
        int   pos, acc_before;
        logic fs, expd;
        string req;
        req = gated ? "R10 gated slave bit" : "R9 free slave bit";
        left_v = l; right_v = r; tl_v = tl; tr_v = tr;
        for (int fc = 0; fc < 64; fc++) begin
            pos = fc % 32;
            fs  = gated ? gate_pat(pat, pos) : 1'($urandom);
            lr_in = (fc < 32); fs_in = fs;
            acc_before = acc_seen;
            repeat (4) @(negedge clk);
            sclk_in = 1'b1;
            repeat (4) @(negedge clk);
            // model of the slot rules
            expd = 1'b0;
            if ((fc < 32) != m_last) begin
                m_last = (fc < 32); m_dcnt = 0;
                if (m_last) begin m_l = l; m_r = r; m_tl = tl; m_tr = tr; end
            end else if (m_dcnt < 16) begin
                if (!gated || fs) begin
                    expd = m_last ? m_l[15-m_dcnt] : m_r[15-m_dcnt];
                    m_dcnt++;
                end
            end else if (m_dcnt < 19) begin
                expd = m_last ? m_tl[18-m_dcnt] : m_tr[18-m_dcnt];
                m_dcnt++;
            end
            chk(sdata_o == expd, req, sdata_o, expd);
            if (fc == 0) begin
                chk(acc_seen == acc_before + 1, "R7 slave accept", acc_seen, acc_before + 1);
                chk(sclk_o == 1'b0 && lr_o == 1'b0 && fsync_o == 1'b0,
                    "R8 slave outputs held low", {sclk_o, lr_o, fsync_o}, 0);
            end
            if (fc == 5) randomize_inputs();
            sclk_in = 1'b0;
        end
    endtask

    initial begin
        void'($urandom(17));
        run_master(1'b0, 3);
        run_master(1'b1, 2);
        do_reset(2'b01, 1'b0);
        slave_frame(1'b0, 0, 16'hFFFF, 16'h0000, 3'b111, 3'b000);
        slave_frame(1'b0, 0, 16'($urandom), 16'($urandom), 3'($urandom), 3'($urandom));
        do_reset(2'b10, 1'b0);
        slave_frame(1'b1, 0, 16'hA5C3, 16'h3C5A, 3'b100, 3'b001);
        slave_frame(1'b1, 1, 16'($urandom), 16'($urandom), 3'($urandom), 3'($urandom));
        slave_frame(1'b1, 0, 16'($urandom), 16'($urandom), 3'($urandom), 3'($urandom));
        do_reset(2'b11, 1'b0);
        slave_frame(1'b1, 0, 16'h8001, 16'h1234, 3'b110, 3'b011);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule